// File: doc/BRIEF.md
# Two-Bank Interleaved Display Memory Arbiter

This block shares one display memory between a processor port and a video fetch port. The storage is split into two physical banks. Consecutive fixed-size address blocks land in alternating banks, so a video stream walking through memory keeps switching banks. Each bank has its own address and data path. When the two ports address different banks in a cycle, both accesses go ahead in that cycle. When they address the same bank, the video fetch takes that bank and the processor is held off until the next cycle.

The processor port uses a valid/ready handshake. It carries a write enable and per-byte strobes, and it keeps its request stable while ready is low. The video port is read-only and is never stalled. Read data on either port comes back one cycle after the access is granted, together with a valid flag. The interleave granularity is a parameter (8 or 16 bytes). The bank-select address bit is derived from it.

Top module: `ilv_mem_arbiter`

## Requirements
- R1: The bank is selected by byte-address bit log2(BLOCK_BYTES). With the default of 16 bytes this is bit 4, so byte addresses 0x00-0x0F and 0x20-0x2F fall in one bank and 0x10-0x1F falls in the other.
- R2: Every video request is accepted in its own cycle. `vid_rvalid` is high in the following cycle and `vid_rdata` then holds the word at `vid_addr`.
- R3: When `cpu_valid` is high and the CPU targets the bank that video is not using in that cycle (or video is idle), `cpu_ready` is high in that same cycle.
- R4: When `cpu_valid` and `vid_req` are both high and both addresses select the same bank, `cpu_ready` is low.
- R5: `cpu_ready` is low whenever `cpu_valid` is low.
- R6: A granted CPU read (`cpu_we`=0) raises `cpu_rvalid` in the next cycle, with `cpu_rdata` holding the addressed word. A granted write, or no grant, leaves `cpu_rvalid` low in the next cycle.
- R7: A granted CPU write updates only the bytes whose bit in `cpu_be` is 1. Bit i covers data bits 8i+7 down to 8i. Bytes whose strobe is 0 keep their old value.
- R8: A CPU write to one bank and a video read from the other bank in the same cycle both complete, and neither disturbs the other's data.
- R9: While reset is active and after its release, `cpu_rvalid` and `vid_rvalid` are low until a new grant occurs.
- R10: Every word address of the full space maps to a distinct storage word. The bank-local address is the byte address with the bank bit and the byte offset removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address (word aligned) |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_be | input | DATA_W/8 | CPU byte strobes |
| cpu_ready | output | 1 | CPU request accepted this cycle |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | DATA_W | CPU read data |
| vid_req | input | 1 | Video word fetch request |
| vid_addr | input | ADDR_W | Video byte address (word aligned) |
| vid_rvalid | output | 1 | Video read data valid |
| vid_rdata | output | DATA_W | Video read data |

## Verification
A CPU access and a video fetch can fall in the same cycle. Whether both complete or the CPU waits depends only on whether their bank-select bits match. The bench provokes this with a video stream that walks through memory word by word while CPU reads and writes go to scattered addresses. It adds directed cases: the same block, a same-bank different block, and the neighbouring block. A flat reference memory in the bench predicts `cpu_ready` for each cycle. It also predicts the data returned on each port one cycle later, so a stall that is missing or wrong, or a write that spills into the other port's read, shows up as a mismatch.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Which port drives a bank in a given cycle
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_VID  = 2'd1,
    OWN_CPU  = 2'd2
  } bank_owner_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WOFF   = 2,
  parameter int unsigned BSEL   = 4,
  parameter int unsigned LOC_W  = ADDR_W - 1 - WOFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bank,
  output logic [LOC_W-1:0]  loc
);
  logic [WOFF-1:0] unused_byte_off;

  always_comb begin
    bank            = addr[BSEL];
    loc             = {addr[ADDR_W-1:BSEL+1], addr[BSEL-1:WOFF]};
    unused_byte_off = addr[WOFF-1:0];
  end
endmodule

// File: rtl/ilv_grant.sv
module ilv_grant
  import ilv_pkg::*;
(
  input  logic        cpu_valid,
  input  logic        cpu_bank,
  input  logic        vid_req,
  input  logic        vid_bank,
  output logic        cpu_grant,
  output bank_owner_e owner [NUM_BANKS]
);
  logic clash;

  always_comb begin
    clash     = vid_req && (vid_bank == cpu_bank);
    cpu_grant = cpu_valid && !clash;
    for (int b = 0; b < NUM_BANKS; b++) begin
      owner[b] = OWN_IDLE;
      if (vid_req && (vid_bank == b[0])) begin
        owner[b] = OWN_VID;
      end else if (cpu_valid && (cpu_bank == b[0])) begin
        owner[b] = OWN_CPU;
      end
    end
  end
endmodule

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LOC_W  = 7,
  parameter int unsigned BE_W   = DATA_W / 8,
  parameter int unsigned DEPTH  = 1 << LOC_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [BE_W-1:0]   be,
  input  logic [LOC_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int i = 0; i < BE_W; i++) begin
        if (be[i]) mem[addr][8*i +: 8] <= wdata[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ilv_mem_arbiter.sv
module ilv_mem_arbiter
  import ilv_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned BLOCK_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_valid,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [DATA_W-1:0]     cpu_wdata,
  input  logic [DATA_W/8-1:0]   cpu_be,
  output logic                  cpu_ready,
  output logic                  cpu_rvalid,
  output logic [DATA_W-1:0]     cpu_rdata,
  input  logic                  vid_req,
  input  logic [ADDR_W-1:0]     vid_addr,
  output logic                  vid_rvalid,
  output logic [DATA_W-1:0]     vid_rdata
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned WOFF  = $clog2(BE_W);
  localparam int unsigned BSEL  = $clog2(BLOCK_BYTES);
  localparam int unsigned LOC_W = ADDR_W - 1 - WOFF;

  logic             cpu_bank, vid_bank;
  logic [LOC_W-1:0] cpu_loc, vid_loc;
  logic             cpu_grant;
  bank_owner_e      owner [NUM_BANKS];
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

  ilv_addr_split #(.ADDR_W(ADDR_W), .WOFF(WOFF), .BSEL(BSEL), .LOC_W(LOC_W)) u_cpu_split (
    .addr(cpu_addr), .bank(cpu_bank), .loc(cpu_loc)
  );
  ilv_addr_split #(.ADDR_W(ADDR_W), .WOFF(WOFF), .BSEL(BSEL), .LOC_W(LOC_W)) u_vid_split (
    .addr(vid_addr), .bank(vid_bank), .loc(vid_loc)
  );

  ilv_grant u_grant (
    .cpu_valid(cpu_valid), .cpu_bank(cpu_bank),
    .vid_req(vid_req),     .vid_bank(vid_bank),
    .cpu_grant(cpu_grant), .owner(owner)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              en, we;
    logic [BE_W-1:0]   be;
    logic [LOC_W-1:0]  addr;

    always_comb begin
      en   = 1'b0;
      we   = 1'b0;
      be   = '0;
      addr = '0;
      unique case (owner[b])
        OWN_VID: begin
          en   = 1'b1;
          addr = vid_loc;
        end
        OWN_CPU: begin
          en   = 1'b1;
          we   = cpu_we;
          be   = cpu_be;
          addr = cpu_loc;
        end
        default: ;
      endcase
    end

    ilv_bank_ram #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_ram (
      .clk(clk), .en(en), .we(we), .be(be), .addr(addr),
      .wdata(cpu_wdata), .rdata(bank_rdata[b])
    );
  end

  // Return path: remember which bank serves each port's read
  logic vid_rv_q, vid_rv_d, vid_bk_q, vid_bk_d;
  logic cpu_rv_q, cpu_rv_d, cpu_bk_q, cpu_bk_d;
  logic vid_bk_en, cpu_bk_en;

  always_comb begin
    vid_rv_d  = vid_req;
    vid_bk_en = vid_req;
    vid_bk_d  = vid_bank;
    cpu_rv_d  = cpu_grant && !cpu_we;
    cpu_bk_en = cpu_rv_d;
    cpu_bk_d  = cpu_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_rv_q <= 1'b0;
      vid_bk_q <= 1'b0;
      cpu_rv_q <= 1'b0;
      cpu_bk_q <= 1'b0;
    end else begin
      vid_rv_q <= vid_rv_d;
      cpu_rv_q <= cpu_rv_d;
      if (vid_bk_en) vid_bk_q <= vid_bk_d;
      if (cpu_bk_en) cpu_bk_q <= cpu_bk_d;
    end
  end

  assign cpu_ready  = cpu_grant;
  assign cpu_rvalid = cpu_rv_q;
  assign vid_rvalid = vid_rv_q;
  assign cpu_rdata  = bank_rdata[cpu_bk_q];
  assign vid_rdata  = bank_rdata[vid_bk_q];
endmodule

// File: rtl/ilv_mem_arbiter_chk.sv
module ilv_mem_arbiter_chk #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned BLOCK_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              vid_req,
  input logic [ADDR_W-1:0] vid_addr,
  input logic              vid_rvalid
);
  localparam int unsigned BSEL = $clog2(BLOCK_BYTES);

  // R2
  p_vid_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req |=> vid_rvalid);
  // R3
  p_parallel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && (!vid_req || (cpu_addr[BSEL] != vid_addr[BSEL]))) |-> cpu_ready);
  // R4
  p_clash_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && vid_req && (cpu_addr[BSEL] == vid_addr[BSEL])) |-> !cpu_ready);
  // R5
  p_idle_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> !cpu_ready);
  // R6
  p_read_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !cpu_we) |=> cpu_rvalid);
  // R6
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready && !cpu_we) |=> !cpu_rvalid);
  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert (!cpu_rvalid && !vid_rvalid);
    end
  end
endmodule

bind ilv_mem_arbiter ilv_mem_arbiter_chk #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
  .vid_req(vid_req), .vid_addr(vid_addr), .vid_rvalid(vid_rvalid)
);

// File: tb/test_ilv_mem_arbiter.sv
module test_ilv_mem_arbiter;
  localparam int PERIOD = 10;
  localparam int WORDS  = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_we, cpu_ready, cpu_rvalid;
  logic [9:0]  cpu_addr, vid_addr;
  logic [31:0] cpu_wdata, cpu_rdata, vid_rdata;
  logic [3:0]  cpu_be;
  logic        vid_req, vid_rvalid;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] ref_mem [WORDS];

  always #(PERIOD/2) clk = ~clk;

  ilv_mem_arbiter i_ilv_mem_arbiter (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .vid_req(vid_req), .vid_addr(vid_addr),
    .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: apply inputs at negedge, check ready, predict, check returns at next negedge
  task automatic cycle(input bit cv, input bit cwe, input logic [9:0] ca, input logic [31:0] cwd,
                       input logic [3:0] cbe, input bit vr, input logic [9:0] va,
                       input string tag, output bit granted);
    bit exp_rdy, exp_crv;
    logic [31:0] exp_crd, exp_vrd;
    cpu_valid = cv; cpu_we = cwe; cpu_addr = ca; cpu_wdata = cwd; cpu_be = cbe;
    vid_req = vr; vid_addr = va;
    #1;
    exp_rdy = cv && !(vr && (ca[4] == va[4]));
    chk(cpu_ready === exp_rdy, (exp_rdy ? "R3/R5" : "R4/R5"), {31'd0, cpu_ready}, {31'd0, exp_rdy});
    exp_crv = exp_rdy && !cwe;
    exp_crd = ref_mem[ca[9:2]];
    exp_vrd = ref_mem[va[9:2]];
    if (exp_rdy && cwe) begin
      for (int i = 0; i < 4; i++)
        if (cbe[i]) ref_mem[ca[9:2]][8*i +: 8] = cwd[8*i +: 8];
    end
    granted = exp_rdy;
    @(posedge clk);
    @(negedge clk);
    chk(cpu_rvalid === exp_crv, "R6", {31'd0, cpu_rvalid}, {31'd0, exp_crv});
    if (exp_crv) chk(cpu_rdata === exp_crd, {"R6/R10 ", tag}, cpu_rdata, exp_crd);
    chk(vid_rvalid === vr, "R2", {31'd0, vid_rvalid}, {31'd0, vr});
    if (vr) chk(vid_rdata === exp_vrd, {"R2/R8 ", tag}, vid_rdata, exp_vrd);
  endtask

  task automatic cpu_op_until(input bit cwe, input logic [9:0] ca, input logic [31:0] cwd,
                              input logic [3:0] cbe, inout logic [9:0] va, input string tag);
    bit g = 0;
    int guard = 0;
    while (!g && guard < 50) begin
      bit vr = ($urandom % 4) != 0;
      cycle(1'b1, cwe, ca, cwd, cbe, vr, va, tag, g);
      if (vr) va = va + 10'd4;
      guard++;
    end
  endtask

  initial begin
    bit g;
    logic [9:0] vptr = 10'd0;
    rst_n = 1'b1;
    cpu_valid = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    vid_req = 0; vid_addr = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cpu_rvalid && !vid_rvalid, "R9 in reset", {30'd0, cpu_rvalid, vid_rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_rvalid && !vid_rvalid, "R9 after release", {30'd0, cpu_rvalid, vid_rvalid}, 32'd0);

    // R10: fill every word with a distinct pattern, video idle
    for (int w = 0; w < WORDS; w++) begin
      ref_mem[w] = 32'hx;
      cycle(1'b1, 1'b1, 10'(w*4), 32'hA500_0000 ^ (w * 32'h0101_0037), 4'hF, 1'b0, 10'd0, "R10 fill", g);
    end
    for (int w = 0; w < WORDS; w++)
      cycle(1'b1, 1'b0, 10'(w*4), 32'd0, 4'h0, 1'b0, 10'd0, "R10 readback", g);

    // R1: directed bank pairs, video on block 0x00
    cycle(1'b1, 1'b0, 10'h010, 0, 0, 1'b1, 10'h000, "R1 neighbour block", g);
    cycle(1'b1, 1'b0, 10'h020, 0, 0, 1'b1, 10'h004, "R1 same bank far block", g);
    cycle(1'b1, 1'b0, 10'h00C, 0, 0, 1'b1, 10'h008, "R1 same block", g);
    cycle(1'b1, 1'b0, 10'h03C, 0, 0, 1'b1, 10'h020, "R1 block 0x30", g);
    cycle(1'b0, 1'b0, 10'h010, 0, 0, 1'b1, 10'h000, "R5 idle", g);

    // R7: partial strobes, then read back
    cycle(1'b1, 1'b1, 10'h044, 32'h1122_3344, 4'b0101, 1'b0, 10'd0, "R7 write", g);
    cycle(1'b1, 1'b0, 10'h044, 0, 0, 1'b0, 10'd0, "R7 readback", g);
    cycle(1'b1, 1'b1, 10'h044, 32'hDEAD_BEEF, 4'b1000, 1'b1, 10'h050, "R7 R8 write", g);
    cycle(1'b1, 1'b0, 10'h044, 0, 0, 1'b1, 10'h054, "R7 readback2", g);

    // R8: CPU write to a word while video reads its neighbour in the other bank
    cycle(1'b1, 1'b1, 10'h010, 32'hCAFE_F00D, 4'hF, 1'b1, 10'h000, "R8 parallel", g);
    cycle(1'b1, 1'b1, 10'h000, 32'h0BAD_CAFE, 4'hF, 1'b1, 10'h010, "R8 parallel2", g);
    cycle(1'b1, 1'b0, 10'h000, 0, 0, 1'b1, 10'h010, "R8 verify", g);

    // Mixed traffic: streaming video, scattered CPU
    for (int n = 0; n < 3000; n++) begin
      logic [9:0]  a  = 10'(($urandom % WORDS) * 4);
      bit          we = $urandom % 2;
      logic [31:0] d  = $urandom;
      logic [3:0]  be = 4'($urandom);
      cpu_op_until(we, a, d, be, vptr, "mixed");
      if (($urandom % 5) == 0) begin
        bit vr = $urandom % 2;
        cycle(1'b0, 1'b0, 10'd0, 0, 0, vr, vptr, "R5 gap", g);
        if (vr) vptr = vptr + 10'd4;
      end
    end

    cycle(1'b0, 1'b0, 10'd0, 0, 0, 1'b0, 10'd0, "drain", g);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule